// File: doc/BRIEF.md
# Way and Set-Group Recency Hit Counters

This monitor sits beside a set-associative cache that already tracks LRU order inside each set. On every cache access it receives a valid strobe, a hit flag, the set index and, for a hit, the recency rank of the hit way inside its set (0 = most recently used). It builds a two-dimensional histogram of hits. One axis is the way rank. The other axis is the recency rank of the set group that holds the accessed set. The monitor keeps its own LRU order across the groups. A separate counter counts every access.

Software or a scheduler turns these counts into miss-rate estimates for smaller caches. A hit counted at way rank i stands for the hits gained by adding one more block to every set. The group axis splits that gain further by how recently the region was touched. A combinational read port selects any cell of the histogram. A clear input zeroes all counts without disturbing the group order. Every counter stops at its maximum value and does not wrap.

Top module: `lru_hit_monitor`

## Requirements
- R1: A valid hit with way rank i, to a set whose group holds rank j before the access, increments hit cell (i, j) by one. No other hit cell changes.
- R2: Every valid access, hit or miss, increments the access counter by one.
- R3: A valid miss leaves every hit cell unchanged.
- R4: The group of a set is the upper GRP_W bits of the set index. With 8 sets and 4 groups, group g holds sets 2g and 2g+1.
- R5: After each valid access, hit or miss, the accessed group takes group rank 0. Groups that were more recent move down one rank. Groups that were less recent keep their rank.
- R6: After reset, group g holds group rank g.
- R7: A counter at its all-ones maximum stays there when it would be incremented.
- R8: A cycle with the valid strobe low and clear low changes no counter and no group rank.
- R9: With clear high, every counter reads zero in the next cycle, and clear wins over an access in the same cycle. That access still updates the group order as in R5.
- R10: The read output shows hit cell (read way rank, read group rank) combinationally. It reflects an access from the clock edge on which that access is taken.
- R11: Reset sets all counters to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of all counters |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_hit_i | input | 1 | The access hit |
| acc_set_i | input | SET_W | Set index of the access |
| acc_rank_i | input | WAY_W | Recency rank of the hit way in its set, 0 = MRU |
| rd_way_i | input | WAY_W | Way rank of the cell to read |
| rd_grp_i | input | GRP_W | Group rank of the cell to read |
| rd_cnt_o | output | CNT_W | Selected hit cell |
| acc_cnt_o | output | CNT_W | Total access count |

## Verification
A corrupted group order never appears directly at the ports. It shows on the next hit to an affected group, when the count lands in the wrong group-rank column of the histogram. The bench therefore reads every cell after every access. A lost or duplicated increment shows in the cell read-out on the cycle after the edge that took the access. A broken saturation or clear shows in the access counter on the same cycle, because that counter sees every access.

// File: rtl/lru_mon_pkg.sv
package lru_mon_pkg;

  localparam int unsigned MIN_GROUPS = 2;

  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/lru_sat_cnt.sv
module lru_sat_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX && !clr_i) |=> cnt_o == CNT_MAX);

  assert_single_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + 1'b1));

endmodule

// File: rtl/lru_grp_order.sv
module lru_grp_order #(
  parameter int unsigned NUM_GROUPS = 4,
  parameter int unsigned GRP_W      = $clog2(NUM_GROUPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [GRP_W-1:0] grp_i,
  output logic [GRP_W-1:0] grp_rank_o
);

  logic [GRP_W-1:0]      rank_q [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] used_mask;

  assign grp_rank_o = rank_q[grp_i];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_rank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rank_q[g] <= GRP_W'(g);
      end else if (upd_i) begin
        if (grp_i == GRP_W'(g))           rank_q[g] <= '0;
        else if (rank_q[g] < grp_rank_o)  rank_q[g] <= rank_q[g] + 1'b1;
      end
    end
  end

  always_comb begin
    used_mask = '0;
    for (int g = 0; g < NUM_GROUPS; g++) used_mask[rank_q[g]] = 1'b1;
  end

  assert_rank_perm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_mask == '1);

  assert_mru_after_access_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> rank_q[$past(grp_i)] == '0);

  assert_order_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(grp_rank_o) || $changed(grp_i));

endmodule

// File: rtl/lru_hit_monitor.sv
module lru_hit_monitor
  import lru_mon_pkg::*;
#(
  parameter  int unsigned NUM_WAYS   = 4,
  parameter  int unsigned NUM_SETS   = 8,
  parameter  int unsigned NUM_GROUPS = 4,
  parameter  int unsigned CNT_W      = 16,
  localparam int unsigned WAY_W      = $clog2(NUM_WAYS),
  localparam int unsigned SET_W      = $clog2(NUM_SETS),
  localparam int unsigned GRP_W      = $clog2(NUM_GROUPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             acc_valid_i,
  input  logic             acc_hit_i,
  input  logic [SET_W-1:0] acc_set_i,
  input  logic [WAY_W-1:0] acc_rank_i,
  input  logic [WAY_W-1:0] rd_way_i,
  input  logic [GRP_W-1:0] rd_grp_i,
  output logic [CNT_W-1:0] rd_cnt_o,
  output logic [CNT_W-1:0] acc_cnt_o
);

  localparam int unsigned NUM_CELLS = NUM_WAYS * NUM_GROUPS;
  localparam int unsigned FLAT_W    = NUM_CELLS * CNT_W;

  if (!is_pow2(NUM_WAYS) || !is_pow2(NUM_SETS) || !is_pow2(NUM_GROUPS) ||
      NUM_GROUPS < MIN_GROUPS || NUM_GROUPS > NUM_SETS) begin : g_bad_cfg
    $error("lru_hit_monitor: unsupported geometry");
  end

  logic [GRP_W-1:0]  acc_grp;
  logic [GRP_W-1:0]  acc_grp_rank;
  logic              hit_ev;
  logic [CNT_W-1:0]  hit_cnt [NUM_WAYS][NUM_GROUPS];
  logic [FLAT_W-1:0] cnt_flat;

  // group = upper set-index bits
  assign acc_grp = acc_set_i[SET_W-1 -: GRP_W];
  assign hit_ev  = acc_valid_i && acc_hit_i;

  lru_grp_order #(
    .NUM_GROUPS (NUM_GROUPS),
    .GRP_W      (GRP_W)
  ) u_grp_order (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_i      (acc_valid_i),
    .grp_i      (acc_grp),
    .grp_rank_o (acc_grp_rank)
  );

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    for (genvar j = 0; j < NUM_GROUPS; j++) begin : g_grp
      logic inc;
      assign inc = hit_ev && (acc_rank_i == WAY_W'(w)) && (acc_grp_rank == GRP_W'(j));

      lru_sat_cnt #(
        .CNT_W (CNT_W)
      ) u_cell (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clear_i),
        .inc_i  (inc),
        .cnt_o  (hit_cnt[w][j])
      );

      assign cnt_flat[(w*NUM_GROUPS + j)*CNT_W +: CNT_W] = hit_cnt[w][j];
    end
  end

  lru_sat_cnt #(
    .CNT_W (CNT_W)
  ) u_acc_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clear_i),
    .inc_i  (acc_valid_i),
    .cnt_o  (acc_cnt_o)
  );

  assign rd_cnt_o = hit_cnt[rd_way_i][rd_grp_i];

  assert_acc_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !clear_i && acc_cnt_o != '1) |=> acc_cnt_o == $past(acc_cnt_o) + 1'b1);

  assert_miss_no_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_hit_i && !clear_i) |=> $stable(cnt_flat));

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_valid_i && !clear_i) |=> ($stable(cnt_flat) && $stable(acc_cnt_o)));

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (acc_cnt_o == '0 && cnt_flat == '0));

endmodule

// File: tb/lru_hit_monitor_tb.sv
module lru_hit_monitor_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;
  localparam int NS = 8;
  localparam int NG = 4;
  localparam int CW = 6;
  localparam int WAY_W = $clog2(NW);
  localparam int SET_W = $clog2(NS);
  localparam int GRP_W = $clog2(NG);
  localparam int MAXV = (1 << CW) - 1;
  localparam int SETS_PER_GRP = NS / NG;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic acc_valid = 1'b0;
  logic acc_hit = 1'b0;
  logic [SET_W-1:0] acc_set = '0;
  logic [WAY_W-1:0] acc_rank = '0;
  logic [WAY_W-1:0] rd_way = '0;
  logic [GRP_W-1:0] rd_grp = '0;
  logic [CW-1:0] rd_cnt;
  logic [CW-1:0] acc_cnt;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  int m_rank [NG];
  int m_cnt [NW][NG];
  int m_acc;

  always #(CLK_PERIOD/2) clk = ~clk;

  lru_hit_monitor #(
    .NUM_WAYS(NW), .NUM_SETS(NS), .NUM_GROUPS(NG), .CNT_W(CW)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear),
    .acc_valid_i(acc_valid), .acc_hit_i(acc_hit),
    .acc_set_i(acc_set), .acc_rank_i(acc_rank),
    .rd_way_i(rd_way), .rd_grp_i(rd_grp),
    .rd_cnt_o(rd_cnt), .acc_cnt_o(acc_cnt)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int g = 0; g < NG; g++) m_rank[g] = g;          // R6
    for (int w = 0; w < NW; w++)
      for (int j = 0; j < NG; j++) m_cnt[w][j] = 0;
    m_acc = 0;
  endtask

  task automatic model_step(input bit v, input bit h, input bit c, input int s, input int r);
    int g;
    int gr;
    if (v) begin
      g  = s / SETS_PER_GRP;                              // R4
      gr = m_rank[g];
      if (!c) begin
        if (m_acc < MAXV) m_acc++;                        // R2 R7
        if (h && m_cnt[r][gr] < MAXV) m_cnt[r][gr]++;     // R1 R3
      end
      for (int k = 0; k < NG; k++) begin                  // R5
        if (k == g) m_rank[k] = 0;
        else if (m_rank[k] < gr) m_rank[k]++;
      end
    end
    if (c) begin                                          // R9
      for (int w = 0; w < NW; w++)
        for (int j = 0; j < NG; j++) m_cnt[w][j] = 0;
      m_acc = 0;
    end
  endtask

  // starts and ends at a falling edge
  task automatic step(input bit v, input bit h, input bit c, input int s, input int r);
    acc_valid = v;
    acc_hit   = h;
    clear     = c;
    acc_set   = SET_W'(s);
    acc_rank  = WAY_W'(r);
    @(posedge clk);
    model_step(v, h, c, s, r);
    @(negedge clk);
    acc_valid = 1'b0;
    acc_hit   = 1'b0;
    clear     = 1'b0;
  endtask

  // inputs idle while reading, so crossing an edge changes nothing (R8)
  task automatic check_all(input string tag);
    for (int w = 0; w < NW; w++)
      for (int j = 0; j < NG; j++) begin
        rd_way = WAY_W'(w);
        rd_grp = GRP_W'(j);
        #1;
        check($sformatf("%s cell(%0d,%0d)", tag, w, j), int'(rd_cnt), m_cnt[w][j]);
      end
    check($sformatf("%s access", tag), int'(acc_cnt), m_acc);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++;
        errors++;
        $display("FAIL watchdog expired got %0d cycles expected completion", cycles);
        finish_run();
      end
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R11 access in reset", int'(acc_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R11 R6 after reset");

    // first hits reveal reset group order: group g rank g (R6)
    for (int s = 0; s < NS; s++)
      for (int r = 0; r < NW; r++) begin
        step(1, 1, 0, s, r);
        check_all("R1 R4 R5 R10 hit sweep");
      end

    // hits in a scattered set order
    for (int n = 0; n < 24; n++) begin
      step(1, 1, 0, (n * 5 + 3) % NS, (n * 3) % NW);
      check_all("R1 R5 scattered hits");
    end

    // misses reorder groups but only touch access counter
    for (int s = NS - 1; s >= 0; s--) begin
      step(1, 0, 0, s, s % NW);
      check_all("R2 R3 R5 miss sweep");
    end
    step(1, 1, 0, 1, 2);
    check_all("R5 hit after misses");

    // idle cycles
    step(0, 1, 0, 6, 3);
    step(0, 0, 0, 2, 1);
    check_all("R8 idle");

    // clear together with an access
    step(1, 1, 1, 7, 1);
    check_all("R9 clear beats access");
    step(1, 1, 0, 0, 0);
    check_all("R9 R5 order kept through clear");

    // saturation
    for (int n = 0; n < MAXV + 8; n++) step(1, 1, 0, 5, 2);
    check_all("R7 saturation");
    step(1, 1, 0, 5, 2);
    check_all("R7 R2 held at max");
    step(1, 1, 0, 3, 3);
    check_all("R7 R1 other cell still counts");

    step(0, 0, 1, 0, 0);
    check_all("R9 plain clear");

    finish_run();
  end

endmodule